// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block turns stereo PCM sample pairs into a three-wire serial audio stream made of a serial clock, a word-select clock and a data line. It runs from a fast bit clock and divides it by four to make the serial clock. A stereo frame has 64 serial-clock periods, so the serial clock runs at 64 times the sample rate. Each channel owns one 32-period half-frame, and the word-select line marks which channel is being sent. Data is always sent most significant bit first.

A 2-bit format select picks one of four framings. Code 00 is I2S: the left channel is sent while word select is low, and the MSB comes one serial clock after the word-select edge. Code 01 is left-justified 20-bit. Code 10 is right-justified 20-bit. Code 11 is right-justified 16-bit. Codes 01, 10 and 11 send the left channel while word select is high. Slots that carry no sample bits drive the data line low.

The sample source offers 20-bit left and right words with a valid/ready handshake. Ready is high for one bit-clock cycle per frame, just before the left half-frame starts. In that same cycle the format select is also captured, so a frame never mixes two framings.

Top module: `serial_audio_tx`

## Requirements
- R1: `sclk_o` is the bit clock divided by four: low for two bit-clock cycles, then high for two. Its period is 40 ns with a 10 ns bit clock.
- R2: A frame is 64 serial-clock periods. Word select holds one level for the 32 periods of the left half and the other level for the 32 periods of the right half.
- R3: `sdata_o` and `lrclk_o` change only on a falling edge of `sclk_o`. They are stable from each rising edge until the next falling edge.
- R4: Polarity: with code 00, `lrclk_o` is low during the left half and high during the right half. With codes 01, 10 and 11, it is high during the left half and low during the right half.
- R5: Code 00: the 20 sample bits occupy half-frame slots 1 to 20 (slot 0 is the first serial clock after the word-select edge), MSB in slot 1.
- R6: Code 01: the 20 sample bits occupy slots 0 to 19, MSB in slot 0.
- R7: Code 10: the 20 sample bits occupy slots 12 to 31, LSB in slot 31, the last slot before the word-select edge.
- R8: Code 11: sample bits 19 down to 4 occupy slots 16 to 31. Bit 19 is in slot 16 and bit 4 is in slot 31. Bits 3 to 0 are never sent.
- R9: Every slot outside the data positions of the active format drives `sdata_o` low.
- R10: `smp_ready` is high for exactly one bit-clock cycle per frame, the last cycle before the falling serial-clock edge that starts the left half. Format, left word and right word are captured only in that cycle. Changes to them at any other time have no effect on the frame being sent.
- R11: If `smp_valid` is low in the ready cycle, the following frame sends all data slots low, with the captured format's word-select polarity.
- R12: While reset is held, `sclk_o`, `lrclk_o`, `sdata_o` and `smp_ready` are low. After reset is released, `smp_ready` first rises after the third rising bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (four times the serial clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 left-justified 20-bit, 10 right-justified 20-bit, 11 right-justified 16-bit |
| smp_valid | input | 1 | Sample pair present |
| smp_left | input | 20 | Left-channel sample word |
| smp_right | input | 20 | Right-channel sample word |
| smp_ready | output | 1 | One-cycle capture strobe per frame |
| sclk_o | output | 1 | Serial clock |
| lrclk_o | output | 1 | Word-select clock |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
A wrong clock-divider phase shows up within a few bit-clock cycles. The serial-clock period changes, or a data or word-select edge lands away from a serial-clock fall, and an edge-placement property fires on that same edge. A wrong slot count or wrong format placement keeps the clocks correct but puts bits in the wrong slots. This is seen in the first frame after the handshake, because every frame is compared bit for bit against an independently computed slot map. A format or sample register that loads outside the handshake cycle corrupts the current frame. The bench catches this by changing all captured inputs right after each handshake.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ20 = 2'b01,
    FMT_RJ20 = 2'b10,
    FMT_RJ16 = 2'b11
  } fmt_e;

  // first half-frame slot that carries the MSB
  function automatic int first_slot(fmt_e f, int half, int wide, int narrow);
    case (f)
      FMT_I2S:  return 1;
      FMT_LJ20: return 0;
      FMT_RJ20: return half - wide;
      default:  return half - narrow;
    endcase
  endfunction

  // number of sample bits placed per half-frame
  function automatic int bit_count(fmt_e f, int wide, int narrow);
    return (f == FMT_RJ16) ? narrow : wide;
  endfunction

  // word-select level while the left channel is being sent
  function automatic logic left_level(fmt_e f);
    return (f != FMT_I2S);
  endfunction

endpackage

// File: rtl/sat_timebase.sv
`timescale 1ns/1ps
module sat_timebase #(
  parameter int CLK_DIV     = 4,
  parameter int FRAME_SLOTS = 64,
  localparam int PH_W = $clog2(CLK_DIV),
  localparam int SL_W = $clog2(FRAME_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            sclk,
  output logic            tick,
  output logic            frame_end,
  output logic [SL_W-1:0] slot_nxt
);

  logic [PH_W-1:0] phase;
  logic [SL_W-1:0] slot;

  assign tick      = (phase == PH_W'(CLK_DIV - 1));
  assign sclk      = (phase >= PH_W'(CLK_DIV / 2));
  assign slot_nxt  = (slot == SL_W'(FRAME_SLOTS - 1)) ? '0 : slot + 1'b1;
  assign frame_end = tick && (slot == SL_W'(FRAME_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      slot  <= SL_W'(FRAME_SLOTS - 1);
    end else begin
      phase <= tick ? '0 : phase + 1'b1;
      if (tick) slot <= slot_nxt;
    end
  end

endmodule

// File: rtl/sat_frame_latch.sv
`timescale 1ns/1ps
module sat_frame_latch
  import sat_pkg::*;
#(
  parameter int SMP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       fmt_in,
  input  logic             valid,
  input  logic [SMP_W-1:0] left_in,
  input  logic [SMP_W-1:0] right_in,
  output logic [1:0]       fmt_nxt,
  output logic [SMP_W-1:0] left_nxt,
  output logic [SMP_W-1:0] right_nxt
);

  logic [1:0]       fmt_q;
  logic [SMP_W-1:0] left_q;
  logic [SMP_W-1:0] right_q;

  always_comb begin
    fmt_nxt   = fmt_q;
    left_nxt  = left_q;
    right_nxt = right_q;
    if (load) begin
      fmt_nxt   = fmt_in;
      left_nxt  = valid ? left_in  : '0;
      right_nxt = valid ? right_in : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q   <= FMT_I2S;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      fmt_q   <= fmt_nxt;
      left_q  <= left_nxt;
      right_q <= right_nxt;
    end
  end

endmodule

// File: rtl/sat_slot_map.sv
`timescale 1ns/1ps
module sat_slot_map
  import sat_pkg::*;
#(
  parameter int SMP_W      = 20,
  parameter int NARROW_W   = 16,
  parameter int HALF_SLOTS = 32,
  localparam int SL_W = $clog2(2 * HALF_SLOTS),
  localparam int IX_W = $clog2(SMP_W)
) (
  input  logic [1:0]       fmt,
  input  logic [SL_W-1:0]  slot,
  input  logic [SMP_W-1:0] left,
  input  logic [SMP_W-1:0] right,
  output logic             lr_lvl,
  output logic             bit_val
);

  fmt_e             f;
  logic             in_right;
  logic [SMP_W-1:0] word;
  logic             live;
  logic [IX_W-1:0]  idx;
  int               pos;
  int               first;
  int               cnt;

  always_comb begin
    f        = fmt_e'(fmt);
    in_right = slot[SL_W-1];
    pos      = int'(slot[SL_W-2:0]);
    first    = first_slot(f, HALF_SLOTS, SMP_W, NARROW_W);
    cnt      = bit_count(f, SMP_W, NARROW_W);
    word     = in_right ? right : left;
    live     = (pos >= first) && (pos < first + cnt);
    idx      = live ? IX_W'(SMP_W - 1 - (pos - first)) : '0;
    bit_val  = live & word[idx];
    lr_lvl   = in_right ? ~left_level(f) : left_level(f);
  end

endmodule

// File: rtl/serial_audio_tx.sv
`timescale 1ns/1ps
module serial_audio_tx #(
  parameter int SMP_W      = 20,
  parameter int NARROW_W   = 16,
  parameter int HALF_SLOTS = 32,
  parameter int CLK_DIV    = 4,
  localparam int FRAME_SLOTS = 2 * HALF_SLOTS,
  localparam int SL_W        = $clog2(FRAME_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_sel,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  output logic             smp_ready,
  output logic             sclk_o,
  output logic             lrclk_o,
  output logic             sdata_o
);

  logic             tick;
  logic             frame_load;
  logic [SL_W-1:0]  slot_nxt;
  logic [1:0]       fmt_nxt;
  logic [SMP_W-1:0] left_nxt;
  logic [SMP_W-1:0] right_nxt;
  logic             lr_next;
  logic             bit_next;
  logic             lrclk_q;
  logic             sdata_q;

  sat_timebase #(.CLK_DIV(CLK_DIV), .FRAME_SLOTS(FRAME_SLOTS)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk_o),
    .tick     (tick),
    .frame_end(frame_load),
    .slot_nxt (slot_nxt)
  );

  sat_frame_latch #(.SMP_W(SMP_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_load),
    .fmt_in   (fmt_sel),
    .valid    (smp_valid),
    .left_in  (smp_left),
    .right_in (smp_right),
    .fmt_nxt  (fmt_nxt),
    .left_nxt (left_nxt),
    .right_nxt(right_nxt)
  );

  sat_slot_map #(.SMP_W(SMP_W), .NARROW_W(NARROW_W), .HALF_SLOTS(HALF_SLOTS)) u_map (
    .fmt    (fmt_nxt),
    .slot   (slot_nxt),
    .left   (left_nxt),
    .right  (right_nxt),
    .lr_lvl (lr_next),
    .bit_val(bit_next)
  );

  // outputs move together with the serial-clock fall
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lrclk_q <= 1'b0;
      sdata_q <= 1'b0;
    end else if (tick) begin
      lrclk_q <= lr_next;
      sdata_q <= bit_next;
    end
  end

  assign smp_ready = frame_load;
  assign lrclk_o   = lrclk_q;
  assign sdata_o   = sdata_q;

endmodule

// File: rtl/serial_audio_tx_chk.sv
`timescale 1ns/1ps
module serial_audio_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_o,
  input logic       lrclk_o,
  input logic       sdata_o,
  input logic       smp_ready,
  input logic       frame_load,
  input logic [1:0] fmt_nxt
);

  AST_SCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |=> sclk_o); // R1
  AST_SCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |=> !sclk_o); // R1
  AST_SDATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $fell(sclk_o)); // R3
  AST_LRCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk_o) |-> $fell(sclk_o)); // R3
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> !smp_ready); // R10
  AST_READY_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> $fell(sclk_o)); // R10
  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |-> $stable(fmt_nxt)); // R10

endmodule

bind serial_audio_tx serial_audio_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk_o    (sclk_o),
  .lrclk_o   (lrclk_o),
  .sdata_o   (sdata_o),
  .smp_ready (smp_ready),
  .frame_load(frame_load),
  .fmt_nxt   (fmt_nxt)
);

// File: tb/serial_audio_tx_test.sv
`timescale 1ns/1ps
module serial_audio_tx_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic        smp_valid;
  logic [19:0] smp_left;
  logic [19:0] smp_right;
  logic        smp_ready;
  logic        sclk_o;
  logic        lrclk_o;
  logic        sdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  serial_audio_tx uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .smp_ready(smp_ready),
    .sclk_o(sclk_o), .lrclk_o(lrclk_o), .sdata_o(sdata_o)
  );

  localparam int NV = 8;
  // {format, left word, right word}
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 20'hA5C3F, 20'h1E0D7},
    {2'b01, 20'hFFFFF, 20'h00001},
    {2'b10, 20'h80001, 20'h7FFFE},
    {2'b11, 20'hC3A5F, 20'h5A3C9},
    {2'b00, 20'h80000, 20'h00001},
    {2'b11, 20'hFFFFF, 20'hFFFFF},
    {2'b10, 20'h12345, 20'hFEDCB},
    {2'b01, 20'h5555A, 20'hAAAA5}
  };

  // expected data bit at half-frame position p, from R5..R9
  function automatic logic exp_data(logic [1:0] f, logic [19:0] w, int p);
    int lo;
    int hi;
    case (f)
      2'b00:   begin lo = 1;  hi = 20; end
      2'b01:   begin lo = 0;  hi = 19; end
      2'b10:   begin lo = 12; hi = 31; end
      default: begin lo = 16; hi = 31; end
    endcase
    if (p < lo || p > hi) return 1'b0;
    return w[19 - (p - lo)];
  endfunction

  // expected word-select level, R4
  function automatic logic exp_lr(logic [1:0] f, bit right_half);
    return (f == 2'b00) ? right_half : !right_half;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic get_frame(output logic [63:0] lr, output logic [63:0] dat,
                           output int unstable, output longint period);
    longint t0;
    unstable = 0;
    t0 = 0;
    period = 0;
    for (int s = 0; s < 64; s++) begin
      @(posedge sclk_o);
      if (s == 0) t0 = $time;
      if (s == 1) period = $time - t0;
      #1;
      lr[s]  = lrclk_o;
      dat[s] = sdata_o;
      if (s < 63) begin
        #13;
        if (sdata_o !== dat[s] || lrclk_o !== lr[s]) unstable++;
      end
    end
  endtask

  task automatic check_frame(logic [1:0] f, logic [19:0] l, logic [19:0] r, string tag);
    logic [63:0] lr_e;
    logic [63:0] dat_e;
    logic [63:0] lr_a;
    logic [63:0] dat_a;
    int          unst;
    longint      per;
    for (int s = 0; s < 64; s++) begin
      lr_e[s]  = exp_lr(f, s >= 32);
      dat_e[s] = exp_data(f, (s >= 32) ? r : l, s % 32);
    end
    get_frame(lr_a, dat_a, unst, per);
    check(lr_a === lr_e, "R2 R4 word-select pattern", lr_a, lr_e);
    check(dat_a === dat_e, {tag, " R9 R10 data slots"}, dat_a, dat_e);
    check(unst == 0, "R3 outputs stable while sclk high", 64'(unst), 64'd0);
    check(per == 40, "R1 sclk period ns", 64'(per), 64'd40);
  endtask

  task automatic wait_handshake();
    do @(negedge clk); while (!smp_ready);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int n;
    rst_n     = 1'b0;
    fmt_sel   = 2'b01;
    smp_valid = 1'b0;
    smp_left  = 20'hFFFFF;
    smp_right = 20'hFFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: quiet outputs in reset
    check({sclk_o, lrclk_o, sdata_o, smp_ready} === 4'b0000, "R12 reset outputs",
          64'({sclk_o, lrclk_o, sdata_o, smp_ready}), 64'd0);
    rst_n = 1'b1;
    n = 0;
    while (!smp_ready) begin
      @(posedge clk);
      n++;
      #1;
    end
    check(n == 3, "R12 first ready after release", 64'(n), 64'd3);
    @(posedge clk);
    #1;
    // R11: first frame taken with valid low
    check_frame(2'b01, 20'h0, 20'h0, "R11 silent frame");

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  f;
      logic [19:0] l;
      logic [19:0] r;
      string       tag;
      {f, l, r} = VEC[i];
      case (f)
        2'b00:   tag = "R5";
        2'b01:   tag = "R6";
        2'b10:   tag = "R7";
        default: tag = "R8";
      endcase
      @(negedge clk);
      fmt_sel   = f;
      smp_left  = l;
      smp_right = r;
      smp_valid = 1'b1;
      wait_handshake();
      // R10: disturb every captured input during the frame
      fmt_sel   = ~f;
      smp_left  = ~l;
      smp_right = ~r;
      check_frame(f, l, r, tag);
    end

    @(negedge clk);
    fmt_sel   = 2'b11;
    smp_valid = 1'b0;
    smp_left  = 20'hFFFFF;
    smp_right = 20'hFFFFF;
    wait_handshake();
    smp_valid = 1'b1;
    check_frame(2'b11, 20'h0, 20'h0, "R11 underrun");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule